// File: doc/BRIEF.md
# Hardware-Loop Micro-Sequencer

This block steps through a small built-in program and emits one control word per cycle. There is no arithmetic unit. A program counter addresses an instruction ROM, and each instruction word carries the control word that is driven out while that instruction executes.

Flow control uses four mechanisms:
- plain stepping;
- a conditional branch that tests one of several condition inputs;
- a counted-loop instruction;
- a call instruction.

The loop and call instructions both push a record onto a single return stack. Each record holds the range start address, the range last address, a pass count and a resume address. Every cycle, the program counter is compared with the last address of the top record. On a match, the sequencer does one of two things in that same cycle, so a loop pass costs no cycles:
- if passes remain, it jumps back to the range start;
- otherwise, it pops the record and resumes.

A called range therefore needs no return instruction, and nested loops and calls share the same stack.

The built-in program exercises every feature. A pulse on the start input runs it from address 0. A halt instruction ends the run and raises the done flag. A push onto a full stack latches an overflow error and stops the sequencer until reset.

Top module: `loop_seq`

## Requirements
- R1: After reset, `ctrl_o` is 0, `done_o` is 0 and `ovf_o` is 0, and they stay so until `start_i` is sampled high.
- R2: `start_i` sampled high while idle or done starts execution at address 0 with an empty stack. Each executing cycle drives the control word of the current instruction. In the built-in program, the control word at address k is 128 + k. A plain instruction (opcode 0) advances to the next address. `ctrl_o` is 0 whenever the sequencer is not executing.
- R3: A loop instruction (opcode 1) with range start a, range last b and count n > 0 executes addresses a..b exactly n times back to back, with no extra cycles between passes, and then continues at b + 1. A one-instruction body (a = b) also repeats n times.
- R4: Loops nest. A loop instruction inside an outer body pushes a fresh record on every outer pass, so an inner body of count 2 inside an outer body of count 2 runs 4 times.
- R5: A loop instruction with n = 0 executes none of its body and continues at b + 1.
- R6: A call instruction (opcode 2) executes range a..b once and then resumes at the address after the call. No return instruction is needed.
- R7: A branch instruction (opcode 3) jumps to address a when the condition input selected by the low 2 bits of its count field is 1, and otherwise goes to the next address. Both backward jumps (including onto itself) and forward jumps work.
- R8: A halt instruction (opcode 4) drives its control word for one cycle; from the next cycle `done_o` is 1 and `ctrl_o` is 0. A new start pulse restarts from address 0.
- R9: With 128 records held, a further push raises `ovf_o` from the next cycle. `ovf_o` stays set and `ctrl_o` stays 0 regardless of `start_i` until reset, and the stack never holds more than 128 records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle or done |
| cond_i | input | 4 | Condition inputs tested by the branch instruction |
| ctrl_o | output | 8 | Control word of the executing instruction, 0 otherwise |
| done_o | output | 1 | High after a halt instruction has executed |
| ovf_o | output | 1 | Sticky return-stack overflow error |

## Verification
A start pulse sampled at one rising edge makes the address-0 control word visible after that edge. After that, each instruction's word appears one cycle after the edge that loaded its address. This also holds for loop-back and pop cycles, which is what makes the zero-overhead claim observable. `done_o` and `ovf_o` rise one cycle after the halt word or the failing push word has been shown.

A behavioural model in the bench keeps the program counter and a queue of stack records. The model is advanced at each falling edge, right after the design's outputs are compared with it, and the next inputs are applied in the same step. Every comparison therefore lines up with the edge that produced it. Counts of the control words seen per address then confirm the loop, skip, call, branch and overflow counts.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;

    parameter int ADDR_W = 6;
    parameter int CTRL_W = 8;
    parameter int CNT_W  = 8;
    parameter int SEL_W  = 2;
    localparam int NCOND  = 1 << SEL_W;
    localparam int NWORDS = 1 << ADDR_W;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_FOR  = 3'd1,
        OP_CALL = 3'd2,
        OP_BRC  = 3'd3,
        OP_HALT = 3'd4
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [CTRL_W-1:0] ctrl;
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] b;
        logic [CNT_W-1:0]  n;
    } instr_t;

    typedef struct packed {
        logic [ADDR_W-1:0] beg_a;
        logic [ADDR_W-1:0] last_a;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] ret_a;
    } stk_ent_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2,
        ST_ERR  = 2'd3
    } seq_st_e;

    function automatic instr_t mk_instr(input op_e op, input int addr,
                                        input int a, input int b, input int n);
        instr_t w;
        w.op   = op;
        w.ctrl = CTRL_W'(128 + addr);
        w.a    = ADDR_W'(a);
        w.b    = ADDR_W'(b);
        w.n    = CNT_W'(n);
        return w;
    endfunction

endpackage

// File: rtl/loop_seq_rom.sv
module loop_seq_rom
    import loop_seq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output instr_t            instr_o
);

    int k;

    always_comb begin
        k = int'(addr_i);
        unique case (addr_i)
            ADDR_W'(1):  instr_o = mk_instr(OP_FOR,  k, 2, 4, 3);
            ADDR_W'(5):  instr_o = mk_instr(OP_FOR,  k, 6, 9, 2);
            ADDR_W'(6):  instr_o = mk_instr(OP_FOR,  k, 7, 8, 2);
            ADDR_W'(10): instr_o = mk_instr(OP_FOR,  k, 11, 11, 0);
            ADDR_W'(12): instr_o = mk_instr(OP_CALL, k, 20, 22, 0);
            ADDR_W'(13): instr_o = mk_instr(OP_BRC,  k, 13, 0, 0);
            ADDR_W'(14): instr_o = mk_instr(OP_BRC,  k, 16, 0, 1);
            ADDR_W'(16): instr_o = mk_instr(OP_FOR,  k, 17, 17, 4);
            ADDR_W'(18): instr_o = mk_instr(OP_BRC,  k, 24, 0, 2);
            ADDR_W'(19): instr_o = mk_instr(OP_HALT, k, 0, 0, 0);
            ADDR_W'(23): instr_o = mk_instr(OP_HALT, k, 0, 0, 0);
            ADDR_W'(24): instr_o = mk_instr(OP_CALL, k, 24, 25, 0);
            ADDR_W'(0), ADDR_W'(2), ADDR_W'(3), ADDR_W'(4), ADDR_W'(7),
            ADDR_W'(8), ADDR_W'(9), ADDR_W'(11), ADDR_W'(15), ADDR_W'(17),
            ADDR_W'(20), ADDR_W'(21), ADDR_W'(22), ADDR_W'(25):
                         instr_o = mk_instr(OP_NOP,  k, 0, 0, 0);
            default:     instr_o = mk_instr(OP_HALT, k, 0, 0, 0);
        endcase
    end

endmodule

// File: rtl/loop_seq_stack.sv
module loop_seq_stack
    import loop_seq_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr_i,
    input  logic     push_i,
    input  logic     pop_i,
    input  logic     dec_i,
    input  stk_ent_t ent_i,
    output stk_ent_t top_o,
    output logic     empty_o,
    output logic     full_o
);

    localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SPW = $clog2(DEPTH + 1);

    stk_ent_t         mem [DEPTH];
    logic [SPW-1:0]   sp_q, sp_d;
    logic [IW-1:0]    top_idx;
    logic [IW-1:0]    push_idx;

    assign top_idx  = IW'(sp_q - SPW'(1));
    assign push_idx = IW'(sp_q);
    assign empty_o  = (sp_q == '0);
    assign full_o   = (sp_q == SPW'(DEPTH));
    assign top_o    = mem[top_idx];

    always_comb begin
        sp_d = sp_q;
        if (clr_i) begin
            sp_d = '0;
        end else if (push_i) begin
            sp_d = sp_q + SPW'(1);
        end else if (pop_i) begin
            sp_d = sp_q - SPW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else begin
            sp_q <= sp_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i && !clr_i) begin
            mem[push_idx] <= ent_i;
        end else if (dec_i && !clr_i) begin
            mem[top_idx].cnt <= mem[top_idx].cnt - CNT_W'(1);
        end
    end

    AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= SPW'(DEPTH)); // R9

    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o); // R9

    AST_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !clr_i) |=> (sp_q == $past(sp_q) - SPW'(1))); // R6

    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i || dec_i) |-> !empty_o); // R3

endmodule

// File: rtl/loop_seq.sv
module loop_seq
    import loop_seq_pkg::*;
#(
    parameter int STACK_DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NCOND-1:0]  cond_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              done_o,
    output logic              ovf_o
);

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] pc;
    } seq_t;

    seq_t     seq_q, seq_d;
    instr_t   ins;
    stk_ent_t top, ent;
    logic     stk_empty, stk_full;
    logic     clr, push, pop, dec;
    logic     running, at_end;

    loop_seq_rom u_rom (
        .addr_i  (seq_q.pc),
        .instr_o (ins)
    );

    loop_seq_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .push_i  (push),
        .pop_i   (pop),
        .dec_i   (dec),
        .ent_i   (ent),
        .top_o   (top),
        .empty_o (stk_empty),
        .full_o  (stk_full)
    );

    assign running = (seq_q.st == ST_RUN);
    assign at_end  = running && !stk_empty && (seq_q.pc == top.last_a);

    always_comb begin
        seq_d = seq_q;
        clr   = 1'b0;
        push  = 1'b0;
        pop   = 1'b0;
        dec   = 1'b0;
        ent   = '0;
        unique case (seq_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    seq_d.st = ST_RUN;
                    seq_d.pc = '0;
                    clr      = 1'b1;
                end
            end
            ST_RUN: begin
                if (at_end) begin
                    if (top.cnt > CNT_W'(1)) begin
                        dec      = 1'b1;
                        seq_d.pc = top.beg_a;
                    end else begin
                        pop      = 1'b1;
                        seq_d.pc = top.ret_a;
                    end
                end else begin
                    unique case (ins.op)
                        OP_FOR: begin
                            if (ins.n == '0) begin
                                seq_d.pc = ins.b + ADDR_W'(1);
                            end else if (stk_full) begin
                                seq_d.st = ST_ERR;
                            end else begin
                                push         = 1'b1;
                                ent.beg_a    = ins.a;
                                ent.last_a   = ins.b;
                                ent.cnt      = ins.n;
                                ent.ret_a    = ins.b + ADDR_W'(1);
                                seq_d.pc     = ins.a;
                            end
                        end
                        OP_CALL: begin
                            if (stk_full) begin
                                seq_d.st = ST_ERR;
                            end else begin
                                push         = 1'b1;
                                ent.beg_a    = ins.a;
                                ent.last_a   = ins.b;
                                ent.cnt      = CNT_W'(1);
                                ent.ret_a    = seq_q.pc + ADDR_W'(1);
                                seq_d.pc     = ins.a;
                            end
                        end
                        OP_BRC: begin
                            if (cond_i[ins.n[SEL_W-1:0]]) begin
                                seq_d.pc = ins.a;
                            end else begin
                                seq_d.pc = seq_q.pc + ADDR_W'(1);
                            end
                        end
                        OP_HALT: begin
                            seq_d.st = ST_DONE;
                        end
                        default: begin
                            seq_d.pc = seq_q.pc + ADDR_W'(1);
                        end
                    endcase
                end
            end
            default: begin
                seq_d = seq_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st <= ST_IDLE;
            seq_q.pc <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ctrl_o = running ? ins.ctrl : '0;
    assign done_o = (seq_q.st == ST_DONE);
    assign ovf_o  = (seq_q.st == ST_ERR);

    AST_LOOP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && top.cnt > CNT_W'(1)) |=> (seq_q.pc == $past(top.beg_a))); // R3

    AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !at_end && ins.op == OP_FOR && ins.n == '0)
            |=> (seq_q.pc == $past(ins.b) + ADDR_W'(1))); // R5

    AST_HALT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !at_end && ins.op == OP_HALT) |=> (done_o && ctrl_o == '0)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (ovf_o && ctrl_o == '0)); // R9

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !ovf_o && start_i) |=> (running && seq_q.pc == '0)); // R2

endmodule

// File: tb/loop_seq_tb.sv
`timescale 1ns/1ps
module loop_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] cond_i = 4'd0;
    logic [7:0] ctrl_o;
    logic       done_o;
    logic       ovf_o;

    loop_seq u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .cond_i  (cond_i),
        .ctrl_o  (ctrl_o),
        .done_o  (done_o),
        .ovf_o   (ovf_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int m_state = 0;
    int m_pc = 0;
    int qb[$], ql[$], qc[$], qr[$];
    int seen[64];
    string tag = "R2";

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // op: 0 plain, 1 loop, 2 call, 3 branch, 4 halt
    function automatic void prog(input int adr, output int op, output int a,
                                 output int b, output int n);
        op = 0; a = 0; b = 0; n = 0;
        case (adr)
            1:  begin op = 1; a = 2;  b = 4;  n = 3; end
            5:  begin op = 1; a = 6;  b = 9;  n = 2; end
            6:  begin op = 1; a = 7;  b = 8;  n = 2; end
            10: begin op = 1; a = 11; b = 11; n = 0; end
            12: begin op = 2; a = 20; b = 22; end
            13: begin op = 3; a = 13; n = 0; end
            14: begin op = 3; a = 16; n = 1; end
            16: begin op = 1; a = 17; b = 17; n = 4; end
            18: begin op = 3; a = 24; n = 2; end
            19, 23: op = 4;
            24: begin op = 2; a = 24; b = 25; end
            0, 2, 3, 4, 7, 8, 9, 11, 15, 17, 20, 21, 22, 25: op = 0;
            default: op = 4;
        endcase
    endfunction

    function automatic void push_rec(input int a, input int b, input int n, input int r);
        if (qb.size() == 128) begin
            m_state = 3;
        end else begin
            qb.push_back(a); ql.push_back(b); qc.push_back(n); qr.push_back(r);
            m_pc = a;
        end
    endfunction

    function automatic void model_step(input bit st, input bit [3:0] c);
        int op, a, b, n, t;
        case (m_state)
            0, 2: if (st) begin
                m_state = 1; m_pc = 0;
                qb.delete(); ql.delete(); qc.delete(); qr.delete();
            end
            1: begin
                prog(m_pc, op, a, b, n);
                t = qb.size() - 1;
                if (t >= 0 && m_pc == ql[t]) begin
                    if (qc[t] > 1) begin
                        qc[t] = qc[t] - 1; m_pc = qb[t];
                    end else begin
                        m_pc = qr[t];
                        void'(qb.pop_back()); void'(ql.pop_back());
                        void'(qc.pop_back()); void'(qr.pop_back());
                    end
                end else begin
                    case (op)
                        1: if (n == 0) m_pc = (b + 1) % 64; else push_rec(a, b, n, (b + 1) % 64);
                        2: push_rec(a, b, 1, (m_pc + 1) % 64);
                        3: m_pc = c[n % 4] ? a : (m_pc + 1) % 64;
                        4: m_state = 2;
                        default: m_pc = (m_pc + 1) % 64;
                    endcase
                end
            end
            default: ;
        endcase
    endfunction

    task automatic tick(input bit st, input bit [3:0] c);
        @(negedge clk);
        chk(tag, "ctrl", int'(ctrl_o), (m_state == 1) ? 128 + m_pc : 0);
        chk(tag, "done", int'(done_o), (m_state == 2) ? 1 : 0);
        chk(tag, "ovf",  int'(ovf_o),  (m_state == 3) ? 1 : 0);
        if (ctrl_o[7] && !ctrl_o[6]) seen[ctrl_o[5:0]]++;
        start_i = st;
        cond_i  = c;
        model_step(st, c);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start_i = 1'b0; cond_i = 4'd0;
        m_state = 0; m_pc = 0;
        qb.delete(); ql.delete(); qc.delete(); qr.delete();
        repeat (3) @(negedge clk);
        chk("R1", "ctrl in reset", int'(ctrl_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic clear_seen();
        foreach (seen[i]) seen[i] = 0;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_seen();
        do_reset();
        tag = "R1";
        repeat (5) tick(1'b0, 4'd0);
        chk("R1", "done idle", int'(done_o), 0);
        chk("R1", "ovf idle", int'(ovf_o), 0);

        // run 1: wait loop held for a while, forward branch taken, no overflow path
        tag = "R2";
        tick(1'b1, 4'b0011);
        for (int k = 0; k < 400 && m_state != 2; k++) begin
            tick(1'b0, {2'b00, 1'b1, (k < 40)});
        end
        repeat (3) tick(1'b0, 4'b0010);
        chk("R8", "done after halt", int'(done_o), 1);
        chk("R3", "loop body word 2", seen[2], 3);
        chk("R3", "loop body word 4", seen[4], 3);
        chk("R3", "one-word body 17", seen[17], 4);
        chk("R4", "outer body word 6", seen[6], 2);
        chk("R4", "inner body word 7", seen[7], 4);
        chk("R4", "outer last word 9", seen[9], 2);
        chk("R5", "zero-count body 11", seen[11], 0);
        chk("R5", "after skip 12", seen[12], 1);
        chk("R6", "called word 21", seen[21], 1);
        chk("R6", "resume word 13 seen", int'(seen[13] > 0), 1);
        chk("R7", "backward wait on 13", int'(seen[13] > 5), 1);
        chk("R7", "forward branch skips 15", seen[15], 0);
        chk("R8", "halt word 19", seen[19], 1);

        // run 2: restart from done, take the self-calling path
        clear_seen();
        tag = "R9";
        tick(1'b1, 4'b0100);
        chk("R8", "restart word 0", int'(ctrl_o), 0);
        tick(1'b0, 4'b0100);
        chk("R8", "restart address 0", int'(ctrl_o), 128);
        for (int k = 0; k < 400 && m_state != 3; k++) begin
            tick(1'b0, 4'b0100);
        end
        tick(1'b0, 4'b0100);
        chk("R9", "ovf raised", int'(ovf_o), 1);
        chk("R9", "self-call visits", seen[24], 129);
        chk("R7", "untaken branch runs 15", seen[15], 1);
        tick(1'b1, 4'b0000);
        repeat (4) tick(1'b0, 4'b0000);
        chk("R9", "ovf sticky over start", int'(ovf_o), 1);
        chk("R9", "ctrl quiet after ovf", int'(ctrl_o), 0);

        do_reset();
        tag = "R1";
        repeat (3) tick(1'b0, 4'd0);
        chk("R1", "ovf cleared by reset", int'(ovf_o), 0);
        chk("R1", "done cleared by reset", int'(done_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule